// File: doc/BRIEF.md
# Bus Traffic Performance Counter Unit

This block sits next to one port of an on-chip bus and measures how busy that port is. It holds a cycle counter and four event counters. Each event counter has its own event-type register, which selects read data beats, write data beats or, on the fourth counter only, both kinds together. Software reaches the block through a simple 32-bit register port. The read data path is combinational, and each write takes effect on the clock edge that samples it.

A typical measurement runs in four steps. Software programs the event types, turns on the wanted counters through the write-1 set register, and writes the control register with the global enable and the two counter-reset bits. To read the results, it clears the global enable so that every counter freezes, and then reads the counters. The three narrow counters are 32 bits wide. The fourth counter is 40 bits wide and is read as a low word and a high byte. When any counter wraps, it raises a sticky overflow flag. The flags can drive an interrupt, and each flag has its own interrupt enable. The start-mode field and the filter and condition registers only hold the values written to them.

Top module: `bus_perf_counter`

## Requirements
- R1: After reset, every counter, the control register, the count enables, the interrupt enables and the overflow flags read 0, and `irq` is low.
- R2: Writing 1 to a bit of the count-enable set register (0x08) sets that enable bit. Writing 1 to a bit of the clear register (0x0C) clears it. Bits written as 0 are left unchanged. Both addresses read back the enable mask. Only bits 0-3 (event counters 0-3) and bit 31 (cycle counter) exist, and all other bits read 0.
- R3: A counter advances only while control bit 0 (global enable) and its own count-enable bit are both 1. Otherwise it holds its value.
- R4: Event code 0x04 counts one per cycle with `rd_beat` high. Event code 0x05 counts one per cycle with `wr_beat` high. Both codes work on every event counter.
- R5: Event code 0x22 on counter 3 counts read and write beats together, adding 2 when both strobes are high in the same cycle. On counters 0-2, code 0x22 counts nothing, and so does any code other than 0x04, 0x05 or 0x22.
- R6: Counter 3 is 40 bits wide. Address 0x40 returns bits 31:0, and address 0x44 returns bits 39:32 in bits 7:0 with bits 31:8 reading 0. Counters 0-2 are read at 0x34, 0x38 and 0x3C, and the cycle counter at 0x48.
- R7: A control (0x04) write with bit 1 set zeroes all event counters, and one with bit 2 set zeroes the cycle counter, on that write's clock edge. A reset takes priority over an increment in the same cycle. Bits 1 and 2 always read 0.
- R8: With control bit 3 clear, the enabled cycle counter adds 1 every clock. With bit 3 set, it adds 1 once every 64 clocks, counted from its last reset.
- R9: When a counter wraps to 0, the overflow flag register (0x18) sets the bit at that counter's enable position. Writing 1 to a flag bit clears it. A wrap in the same cycle as the clear leaves the flag set.
- R10: `irq` is high exactly when some overflow flag is set and its interrupt enable is set. The interrupt enables are changed through the set register (0x10) and the clear register (0x14), which use the write-1 rule of R2.
- R11: Control bits 21:20 and the store-only registers at 0x1C-0x30 and 0x220-0x22C read back the value last written to them and have no effect on counting.
- R12: The event-type register of counter n sits at 0x200 + 4n and reads back the 8-bit code written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| rd_beat | input | 1 | One read data beat on the monitored port this cycle |
| wr_beat | input | 1 | One write data beat on the monitored port this cycle |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench holds `rd_beat` high across a counter-reset write. A design that let the increment win over the reset would leave a nonzero count. It compares the combined event code on counter 3 with the same code on counter 2, using cycles where both strobes are high. This catches a counter 3 that adds only 1 for a double beat, and a narrow counter that accepts the code. It brings an 8-bit counter and a 10-bit cycle counter to exactly one step before the wrap and then one step past it. A design that flagged the wrap one step early or late, or put the flag in the wrong bit, fails there. The bench also checks the divided cycle count and that the counters freeze while the global enable is low. These catch an off-by-one prescaler and counters that keep running after software has stopped them.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    localparam int AW      = 12;
    localparam int DW      = 32;
    localparam int NUM_EV  = 4;
    localparam int CODE_W  = 8;
    localparam int NUM_CFG = 10;
    localparam int CYC_BIT = 31;

    localparam logic [AW-1:0] A_CTRL    = 12'h004;
    localparam logic [AW-1:0] A_CEN_SET = 12'h008;
    localparam logic [AW-1:0] A_CEN_CLR = 12'h00C;
    localparam logic [AW-1:0] A_IEN_SET = 12'h010;
    localparam logic [AW-1:0] A_IEN_CLR = 12'h014;
    localparam logic [AW-1:0] A_FLAG    = 12'h018;
    localparam logic [AW-1:0] A_EV_BASE = 12'h034;
    localparam logic [AW-1:0] A_WIDE_LO = 12'h040;
    localparam logic [AW-1:0] A_WIDE_HI = 12'h044;
    localparam logic [AW-1:0] A_CYC     = 12'h048;
    localparam logic [AW-1:0] A_TYPE    = 12'h200;
    localparam logic [AW-1:0] A_CFG_LO0 = 12'h01C;
    localparam logic [AW-1:0] A_CFG_LO1 = 12'h030;
    localparam logic [AW-1:0] A_CFG_HI0 = 12'h220;
    localparam logic [AW-1:0] A_CFG_HI1 = 12'h22C;
    localparam int CFG_LO_N = 6;

    localparam logic [CODE_W-1:0] EV_RD   = 8'h04;
    localparam logic [CODE_W-1:0] EV_WR   = 8'h05;
    localparam logic [CODE_W-1:0] EV_BOTH = 8'h22;

    localparam logic [DW-1:0] LIVE_MASK = (DW'(1) << CYC_BIT) | ((DW'(1) << NUM_EV) - DW'(1));

    typedef struct packed {
        logic                          run;
        logic                          div;
        logic [1:0]                    mode;
        logic [DW-1:0]                 cen;
        logic [DW-1:0]                 ien;
        logic [DW-1:0]                 flag;
        logic [NUM_EV-1:0][CODE_W-1:0] evt;
        logic [NUM_CFG-1:0][DW-1:0]    cfg;
    } ctl_t;

    // {hit, slot index} of a store-only register
    function automatic logic [4:0] cfg_slot(input logic [AW-1:0] a);
        logic [AW-1:0] off;
        cfg_slot = '0;
        if (a[1:0] == 2'b00 && a >= A_CFG_LO0 && a <= A_CFG_LO1) begin
            off = a - A_CFG_LO0;
            cfg_slot = {1'b1, off[5:2]};
        end else if (a[1:0] == 2'b00 && a >= A_CFG_HI0 && a <= A_CFG_HI1) begin
            off = a - A_CFG_HI0;
            cfg_slot = {1'b1, 4'(CFG_LO_N) + {2'b00, off[3:2]}};
        end
    endfunction
endpackage

// File: rtl/bpc_event_counter.sv
module bpc_event_counter
    import bpc_pkg::*;
#(
    parameter int W       = 32,
    parameter bit BOTH_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    input  logic              rd_beat,
    input  logic              wr_beat,
    output logic [W-1:0]      count,
    output logic              wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ec_t;

    ec_t        st_d, st_q;
    logic [1:0] step;
    logic [1:0] both_step;
    logic [W:0] sum;

    generate
        if (BOTH_OK) begin : g_both
            assign both_step = {1'b0, rd_beat} + {1'b0, wr_beat};
        end else begin : g_narrow
            assign both_step = 2'd0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        case (code)
            EV_RD:   step = {1'b0, rd_beat};
            EV_WR:   step = {1'b0, wr_beat};
            EV_BOTH: step = both_step;
            default: step = 2'd0;
        endcase
        sum = {1'b0, st_q.cnt} + (W+1)'(step);
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = sum[W-1:0];
            wrap     = sum[W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/bpc_cycle_counter.sv
module bpc_cycle_counter #(
    parameter int W        = 32,
    parameter int DIV_LOG2 = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic         div_en,
    output logic [W-1:0] count,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0]        cnt;
        logic [DIV_LOG2-1:0] pre;
    } cc_t;

    cc_t        st_d, st_q;
    logic       tick;
    logic [W:0] sum;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        tick = !div_en || (&st_q.pre);
        sum  = {1'b0, st_q.cnt} + (W+1)'(1);
        if (clr) begin
            st_d = '0;
        end else if (run) begin
            if (div_en) st_d.pre = st_q.pre + DIV_LOG2'(1);
            if (tick) begin
                st_d.cnt = sum[W-1:0];
                wrap     = sum[W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/bpc_regs.sv
module bpc_regs
    import bpc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 wdata,
    output logic [DW-1:0]                 rdata,
    input  logic [DW-1:0]                 wrap_vec,
    input  logic [NUM_EV-1:0][DW-1:0]     ev_lo,
    input  logic [7:0]                    wide_hi,
    input  logic [DW-1:0]                 cyc,
    output logic                          gen_en,
    output logic                          div_en,
    output logic [DW-1:0]                 cnt_en,
    output logic [DW-1:0]                 int_en,
    output logic [DW-1:0]                 ovf_flag,
    output logic [NUM_EV-1:0][CODE_W-1:0] evt_code,
    output logic                          clr_ev,
    output logic                          clr_cyc,
    output logic                          irq
);
    ctl_t       st_d, st_q;
    logic [4:0] wslot;
    logic [4:0] rslot;
    logic       ctrl_wr;

    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign clr_ev  = ctrl_wr && wdata[1];
    assign clr_cyc = ctrl_wr && wdata[2];

    always_comb begin
        st_d  = st_q;
        wslot = cfg_slot(addr);
        if (wr_en) begin
            if (addr == A_CTRL) begin
                st_d.run  = wdata[0];
                st_d.div  = wdata[3];
                st_d.mode = wdata[21:20];
            end else if (addr == A_CEN_SET) begin
                st_d.cen = st_q.cen | (wdata & LIVE_MASK);
            end else if (addr == A_CEN_CLR) begin
                st_d.cen = st_q.cen & ~(wdata & LIVE_MASK);
            end else if (addr == A_IEN_SET) begin
                st_d.ien = st_q.ien | (wdata & LIVE_MASK);
            end else if (addr == A_IEN_CLR) begin
                st_d.ien = st_q.ien & ~(wdata & LIVE_MASK);
            end else if (addr == A_FLAG) begin
                st_d.flag = st_q.flag & ~(wdata & LIVE_MASK);
            end else if (wslot[4]) begin
                st_d.cfg[wslot[3:0]] = wdata;
            end
            for (int n = 0; n < NUM_EV; n++) begin
                if (addr == A_TYPE + AW'(4 * n)) st_d.evt[n] = wdata[CODE_W-1:0];
            end
        end
        // a wrap in the same cycle as a clear keeps the flag set
        st_d.flag = st_d.flag | (wrap_vec & LIVE_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        rslot = cfg_slot(addr);
        if (addr == A_CTRL) begin
            rdata[0]     = st_q.run;
            rdata[3]     = st_q.div;
            rdata[21:20] = st_q.mode;
        end else if (addr == A_CEN_SET || addr == A_CEN_CLR) begin
            rdata = st_q.cen;
        end else if (addr == A_IEN_SET || addr == A_IEN_CLR) begin
            rdata = st_q.ien;
        end else if (addr == A_FLAG) begin
            rdata = st_q.flag;
        end else if (addr == A_WIDE_LO) begin
            rdata = ev_lo[NUM_EV-1];
        end else if (addr == A_WIDE_HI) begin
            rdata = {24'd0, wide_hi};
        end else if (addr == A_CYC) begin
            rdata = cyc;
        end else if (rslot[4]) begin
            rdata = st_q.cfg[rslot[3:0]];
        end
        for (int n = 0; n < NUM_EV - 1; n++) begin
            if (addr == A_EV_BASE + AW'(4 * n)) rdata = ev_lo[n];
        end
        for (int n = 0; n < NUM_EV; n++) begin
            if (addr == A_TYPE + AW'(4 * n)) rdata = {{(DW-CODE_W){1'b0}}, st_q.evt[n]};
        end
    end

    assign gen_en   = st_q.run;
    assign div_en   = st_q.div;
    assign cnt_en   = st_q.cen;
    assign int_en   = st_q.ien;
    assign ovf_flag = st_q.flag;
    assign evt_code = st_q.evt;
    assign irq      = |(st_q.flag & st_q.ien);
endmodule

// File: rtl/bus_perf_counter.sv
module bus_perf_counter
    import bpc_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int WIDE_W   = 40,
    parameter int CYC_W    = 32,
    parameter int DIV_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          rd_beat,
    input  logic          wr_beat,
    output logic          irq
);
    logic                          gen_en;
    logic                          div_en;
    logic [DW-1:0]                 cnt_en;
    logic [DW-1:0]                 int_en;
    logic [DW-1:0]                 ovf_flag;
    logic [NUM_EV-1:0][CODE_W-1:0] evt_code;
    logic                          clr_ev;
    logic                          clr_cyc;
    logic [NUM_EV-1:0][DW-1:0]     ev_lo;
    logic [NUM_EV-1:0]             ev_wrap;
    logic [7:0]                    wide_hi;
    logic [DW-1:0]                 cyc_lo;
    logic                          cyc_wrap;
    logic [DW-1:0]                 wrap_vec;

    generate
        for (genvar n = 0; n < NUM_EV; n++) begin : g_ev
            if (n == NUM_EV - 1) begin : g_wide
                logic [WIDE_W-1:0] c;
                bpc_event_counter #(.W(WIDE_W), .BOTH_OK(1'b1)) u_cnt (
                    .clk(clk), .rst_n(rst_n), .run(gen_en && cnt_en[n]), .clr(clr_ev),
                    .code(evt_code[n]), .rd_beat(rd_beat), .wr_beat(wr_beat),
                    .count(c), .wrap(ev_wrap[n])
                );
                assign ev_lo[n] = DW'(c);
                assign wide_hi  = 8'(c >> DW);
            end else begin : g_narrow
                logic [CNT_W-1:0] c;
                bpc_event_counter #(.W(CNT_W), .BOTH_OK(1'b0)) u_cnt (
                    .clk(clk), .rst_n(rst_n), .run(gen_en && cnt_en[n]), .clr(clr_ev),
                    .code(evt_code[n]), .rd_beat(rd_beat), .wr_beat(wr_beat),
                    .count(c), .wrap(ev_wrap[n])
                );
                assign ev_lo[n] = DW'(c);
            end
        end
    endgenerate

    logic [CYC_W-1:0] cyc_cnt;

    bpc_cycle_counter #(.W(CYC_W), .DIV_LOG2(DIV_LOG2)) u_cyc (
        .clk(clk), .rst_n(rst_n), .run(gen_en && cnt_en[CYC_BIT]), .clr(clr_cyc),
        .div_en(div_en), .count(cyc_cnt), .wrap(cyc_wrap)
    );
    assign cyc_lo = DW'(cyc_cnt);

    always_comb begin
        wrap_vec                = '0;
        wrap_vec[NUM_EV-1:0]    = ev_wrap;
        wrap_vec[CYC_BIT]       = cyc_wrap;
    end

    bpc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .wrap_vec(wrap_vec), .ev_lo(ev_lo), .wide_hi(wide_hi),
        .cyc(cyc_lo), .gen_en(gen_en), .div_en(div_en), .cnt_en(cnt_en), .int_en(int_en),
        .ovf_flag(ovf_flag), .evt_code(evt_code), .clr_ev(clr_ev), .clr_cyc(clr_cyc),
        .irq(irq)
    );
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
    import bpc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_en,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          irq,
    input logic          gen_en,
    input logic          cen0,
    input logic          cen_cyc,
    input logic [DW-1:0] int_en,
    input logic          flag0,
    input logic [DW-1:0] ev0,
    input logic [DW-1:0] ev_wide,
    input logic [DW-1:0] cyc,
    input logic          wrap0
);
    logic ctl_wr;
    assign ctl_wr = reg_wr_en && reg_addr == A_CTRL;

    a_r2_set_on: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == A_CEN_SET && reg_wdata[0] |=> cen0);
    a_r2_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_addr == A_CEN_CLR && reg_wdata[0] |=> !cen0);
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en && !(ctl_wr && reg_wdata[1]) |=> $stable(ev0) && $stable(ev_wide));
    a_r7_event_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && reg_wdata[1] |=> ev0 == '0 && ev_wide == '0);
    a_r7_cycle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && reg_wdata[2] |=> cyc == '0);
    a_r7_reset_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == A_CTRL |-> reg_rdata[2:1] == 2'b00);
    a_r8_cycle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_en && cen_cyc) && !(ctl_wr && reg_wdata[2]) |=> $stable(cyc));
    a_r9_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap0 |=> flag0);
    a_r10_no_irq_unenabled: assert property (@(posedge clk) disable iff (!rst_n)
        int_en == '0 |-> !irq);
    a_r6_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == A_WIDE_HI |-> reg_rdata[31:8] == 24'd0);
endmodule

bind bus_perf_counter bpc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .gen_en(gen_en),
    .cen0(cnt_en[0]), .cen_cyc(cnt_en[31]), .int_en(int_en), .flag0(ovf_flag[0]),
    .ev0(ev_lo[0]), .ev_wide(ev_lo[3]), .cyc(cyc_lo), .wrap0(ev_wrap[0])
);

// File: tb/bus_perf_counter_bench.sv
module bus_perf_counter_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;
    logic        irq;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bus_perf_counter #(.CNT_W(8), .WIDE_W(40), .CYC_W(10), .DIV_LOG2(6)) u_bus_perf_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_beat(rd_beat),
        .wr_beat(wr_beat), .irq(irq)
    );

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: addr %h got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        #1;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic beats(input logic r, input logic w, input int n);
        rd_beat = r; wr_beat = w;
        repeat (n) @(negedge clk);
        rd_beat = 1'b0; wr_beat = 1'b0;
    endtask

    task automatic t_reset_state();
        rd_chk(12'h004, 32'h0, "R1 ctrl");
        rd_chk(12'h008, 32'h0, "R1 count enable");
        rd_chk(12'h010, 32'h0, "R1 irq enable");
        rd_chk(12'h018, 32'h0, "R1 flags");
        rd_chk(12'h034, 32'h0, "R1 counter0");
        rd_chk(12'h040, 32'h0, "R1 counter3");
        rd_chk(12'h048, 32'h0, "R1 cycles");
        irq_chk(1'b0, "R1 irq");
    endtask

    task automatic t_enables();
        reg_wr(12'h008, 32'h8000_0003);
        rd_chk(12'h008, 32'h8000_0003, "R2 set");
        reg_wr(12'h00C, 32'h0000_0001);
        rd_chk(12'h00C, 32'h8000_0002, "R2 clear one bit");
        reg_wr(12'h008, 32'h0);
        rd_chk(12'h008, 32'h8000_0002, "R2 zero write no effect");
        reg_wr(12'h008, 32'hFFFF_FFFF);
        rd_chk(12'h008, 32'h8000_000F, "R2 only live bits");
        reg_wr(12'h00C, 32'hFFFF_FFFF);
        rd_chk(12'h00C, 32'h0, "R2 clear all");
    endtask

    task automatic t_events();
        reg_wr(12'h200, 32'h04);
        reg_wr(12'h204, 32'h05);
        reg_wr(12'h208, 32'h22);
        reg_wr(12'h20C, 32'h22);
        rd_chk(12'h200, 32'h04, "R12 type0");
        rd_chk(12'h208, 32'h22, "R12 type2");
        rd_chk(12'h20C, 32'h22, "R12 type3");
        reg_wr(12'h008, 32'h0000_000F);
        reg_wr(12'h004, 32'h7);
        beats(1'b1, 1'b0, 5);
        beats(1'b0, 1'b1, 3);
        beats(1'b1, 1'b1, 2);
        rd_chk(12'h034, 32'd7, "R4 read beats counter0");
        rd_chk(12'h038, 32'd5, "R4 write beats counter1");
        rd_chk(12'h03C, 32'd0, "R5 combined code on counter2");
        rd_chk(12'h040, 32'd12, "R5 combined code on counter3");
        reg_wr(12'h004, 32'h0);
        beats(1'b1, 1'b1, 4);
        rd_chk(12'h034, 32'd7, "R3 frozen counter0");
        rd_chk(12'h040, 32'd12, "R3 frozen counter3");
        reg_wr(12'h004, 32'h1);
        reg_wr(12'h00C, 32'h1);
        beats(1'b1, 1'b0, 3);
        rd_chk(12'h034, 32'd7, "R3 own enable off");
        rd_chk(12'h040, 32'd15, "R3 own enable on");
    endtask

    task automatic t_reset_wins();
        rd_beat = 1'b1; wr_beat = 1'b1;
        reg_wr(12'h004, 32'h3);
        rd_beat = 1'b0; wr_beat = 1'b0;
        rd_chk(12'h040, 32'd0, "R7 reset beats increment");
        rd_chk(12'h038, 32'd0, "R7 counter1 reset");
        rd_chk(12'h004, 32'h1, "R7 reset bits read zero");
    endtask

    task automatic t_overflow();
        reg_wr(12'h008, 32'h1);
        reg_wr(12'h010, 32'h1);
        beats(1'b1, 1'b0, 255);
        rd_chk(12'h034, 32'd255, "R9 one before wrap");
        rd_chk(12'h018, 32'h0, "R9 no flag before wrap");
        irq_chk(1'b0, "R10 irq before wrap");
        beats(1'b1, 1'b0, 1);
        rd_chk(12'h034, 32'd0, "R9 wrapped value");
        rd_chk(12'h018, 32'h1, "R9 flag set");
        irq_chk(1'b1, "R10 irq raised");
        reg_wr(12'h014, 32'h1);
        irq_chk(1'b0, "R10 irq masked");
        rd_chk(12'h018, 32'h1, "R10 flag kept while masked");
        reg_wr(12'h010, 32'h1);
        irq_chk(1'b1, "R10 irq unmasked");
        reg_wr(12'h018, 32'h1);
        rd_chk(12'h018, 32'h0, "R9 flag cleared");
        irq_chk(1'b0, "R10 irq dropped");
    endtask

    task automatic t_cycles();
        reg_wr(12'h008, 32'h8000_0000);
        reg_wr(12'h004, 32'h5);
        repeat (20) @(negedge clk);
        rd_chk(12'h048, 32'd20, "R8 every clock");
        reg_wr(12'h004, 32'hD);
        repeat (130) @(negedge clk);
        rd_chk(12'h048, 32'd2, "R8 divided by 64");
        reg_wr(12'h004, 32'h5);
        repeat (1023) @(negedge clk);
        rd_chk(12'h048, 32'd1023, "R9 cycle before wrap");
        rd_chk(12'h018, 32'h0, "R9 cycle flag clear");
        repeat (1) @(negedge clk);
        rd_chk(12'h048, 32'd0, "R9 cycle wrapped");
        rd_chk(12'h018, 32'h8000_0000, "R9 cycle flag bit31");
        reg_wr(12'h018, 32'h8000_0000);
        rd_chk(12'h018, 32'h0, "R9 cycle flag cleared");
    endtask

    task automatic t_wide();
        rd_chk(12'h040, 32'd256, "R6 wide low word");
        rd_chk(12'h044, 32'd0, "R6 wide high byte");
    endtask

    task automatic t_store_only();
        reg_wr(12'h004, 32'h0020_0001);
        rd_chk(12'h004, 32'h0020_0001, "R11 mode field");
        reg_wr(12'h01C, 32'hA5A5_0001);
        reg_wr(12'h22C, 32'h1234_5678);
        rd_chk(12'h01C, 32'hA5A5_0001, "R11 low config slot");
        rd_chk(12'h22C, 32'h1234_5678, "R11 high config slot");
        reg_wr(12'h008, 32'h2);
        beats(1'b0, 1'b1, 4);
        rd_chk(12'h038, 32'd4, "R11 counting unaffected");
        reg_wr(12'h204, 32'h07);
        beats(1'b1, 1'b1, 3);
        rd_chk(12'h038, 32'd4, "R5 unused code counts nothing");
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_enables();
        t_events();
        t_reset_wins();
        t_overflow();
        t_cycles();
        t_wide();
        t_store_only();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end
endmodule